// File: doc/BRIEF.md
# UDP Header Insertion Engine

This block takes a payload frame of arbitrary length on a byte-wide AXI4-Stream input and sends it out as a complete UDP datagram on a second byte-wide AXI4-Stream output. The input marks the final payload byte of a frame with tlast. Eight header bytes go out ahead of the payload. They carry the configured source port, the configured destination port, the datagram length and the checksum. The checksum includes an IP pseudo-header built from the configured source and destination IPv4 addresses.

Neither the length nor the checksum is known until the last payload byte has arrived. The block therefore holds the payload in a data FIFO while a running sum and byte count are accumulated. When the final byte is accepted, the finished header is pushed into a small header FIFO that sits beside the data FIFO. The output side takes one header, sends its eight bytes, and then drains that frame's payload. Meanwhile the input side can already accept the next frame.

Each frame must hold at least one payload byte and at most `DATA_DEPTH` bytes. The port and address inputs are captured on the cycle in which the frame's final byte is accepted.

Top module: `udp_hdr_insert`

## Requirements
- R1: Each output datagram begins with eight header bytes, each 16-bit field sent most significant byte first, in this order: source port, destination port, length, checksum. The port fields carry the values on `src_port_i` and `dst_port_i` at the cycle the frame's final input byte is accepted. The header bytes never carry tlast.
- R2: The length field equals the payload byte count plus 8.
- R3: The checksum field is the ones'-complement of the 16-bit ones'-complement sum of the following words:
  - the two halves of `src_ip_i`;
  - the two halves of `dst_ip_i`;
  - the constant 17;
  - the length, counted twice (once for the pseudo-header and once for the header);
  - both ports;
  - the payload, taken as big-endian 16-bit words, with an odd final byte padded by a zero low byte.
- R4: A checksum that computes to 0x0000 is sent as 0xFFFF, so the checksum field never carries 0x0000.
- R5: The payload bytes follow the header unchanged and in order. Output tlast is high only on the last payload byte, and no byte is dropped or added.
- R6: While `m_tvalid_o` is high and `m_tready_i` is low, `m_tvalid_o`, `m_tdata_o` and `m_tlast_o` keep their values into the next cycle.
- R7: `s_tready_o` is low whenever the data FIFO or the header FIFO is full. Further input bytes then wait and are not lost.
- R8: After reset `m_tvalid_o` is low and `s_tready_o` is high.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_port_i | input | 16 | UDP source port |
| dst_port_i | input | 16 | UDP destination port |
| src_ip_i | input | 32 | IPv4 source address for the pseudo-header |
| dst_ip_i | input | 32 | IPv4 destination address for the pseudo-header |
| s_tdata_i | input | 8 | Payload byte in |
| s_tvalid_i | input | 1 | Payload byte valid |
| s_tlast_i | input | 1 | Final payload byte of the frame |
| s_tready_o | output | 1 | Input can accept a byte |
| m_tdata_o | output | 8 | Datagram byte out |
| m_tvalid_o | output | 1 | Output byte valid |
| m_tlast_o | output | 1 | Final byte of the datagram |
| m_tready_i | input | 1 | Downstream accepts the byte |

## Verification
Each kind of internal fault shows up at the output in its own way:

- A wrong accumulator or byte count first shows in the length or checksum bytes of the affected datagram. It appears as soon as that datagram's header is sent, one cycle after its final input byte is accepted if the output is idle.
- A header sequencer that is out of step places tlast wrongly, or mixes header bytes into payload bytes. Every following datagram is then misaligned.
- A FIFO pointer or full-flag error loses or repeats bytes. Such an error can also leave `s_tready_o` high while the storage is full, which is visible during an output stall.

// File: rtl/udp_ins_pkg.sv
`timescale 1ns/1ps
package udp_ins_pkg;
  localparam int unsigned HDR_BYTES = 8;
  localparam logic [15:0] IP_PROTO_UDP = 16'd17;

  typedef struct packed {
    logic [15:0] sport;
    logic [15:0] dport;
    logic [15:0] len;
    logic [15:0] cks;
  } udp_hdr_t;
endpackage

// File: rtl/udp_ins_fifo.sv
`timescale 1ns/1ps
module udp_ins_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [AW:0]      cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/udp_ins_sum.sv
`timescale 1ns/1ps
module udp_ins_sum
  import udp_ins_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        beat_i,
  input  logic [7:0]  byte_i,
  input  logic        last_i,
  input  logic [15:0] src_port_i,
  input  logic [15:0] dst_port_i,
  input  logic [31:0] src_ip_i,
  input  logic [31:0] dst_ip_i,
  output udp_hdr_t    hdr_o
);
  logic [31:0] acc_q, acc_n, total, f1, f2;
  logic [15:0] cnt_q, len;
  logic [15:0] cks_raw;

  // even byte index -> high half of word, odd -> low half
  always_comb begin
    acc_n = acc_q + (cnt_q[0] ? {24'h0, byte_i} : {16'h0, byte_i, 8'h0});
    len   = cnt_q + 16'd9;
    total = acc_n
          + {16'h0, src_ip_i[31:16]} + {16'h0, src_ip_i[15:0]}
          + {16'h0, dst_ip_i[31:16]} + {16'h0, dst_ip_i[15:0]}
          + {16'h0, IP_PROTO_UDP}
          + {15'h0, len, 1'b0}
          + {16'h0, src_port_i} + {16'h0, dst_port_i};
    f1      = {16'h0, total[15:0]} + {16'h0, total[31:16]};
    f2      = {16'h0, f1[15:0]} + {16'h0, f1[31:16]};
    cks_raw = ~f2[15:0];
    hdr_o.sport = src_port_i;
    hdr_o.dport = dst_port_i;
    hdr_o.len   = len;
    hdr_o.cks   = (cks_raw == 16'h0000) ? 16'hFFFF : cks_raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (beat_i) begin
      acc_q <= last_i ? '0 : acc_n;
      cnt_q <= last_i ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/udp_ins_tx.sv
`timescale 1ns/1ps
module udp_ins_tx
  import udp_ins_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  udp_hdr_t   hdr_i,
  input  logic       hdr_empty_i,
  output logic       hdr_pop_o,
  input  logic [7:0] dat_i,
  input  logic       dat_last_i,
  input  logic       dat_empty_i,
  output logic       dat_pop_o,
  output logic [7:0] m_tdata_o,
  output logic       m_tvalid_o,
  output logic       m_tlast_o,
  input  logic       m_tready_i
);
  logic       in_pay_q;
  logic [2:0] idx_q;
  logic       hs;

  always_comb begin
    if (!in_pay_q) begin
      m_tvalid_o = !hdr_empty_i;
      m_tdata_o  = hdr_i[63 - 8*int'(idx_q) -: 8];
      m_tlast_o  = 1'b0;
    end else begin
      m_tvalid_o = !dat_empty_i;
      m_tdata_o  = dat_i;
      m_tlast_o  = dat_last_i;
    end
    hs        = m_tvalid_o && m_tready_i;
    hdr_pop_o = hs && !in_pay_q && (idx_q == 3'd7);
    dat_pop_o = hs && in_pay_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pay_q <= 1'b0;
      idx_q    <= '0;
    end else if (hs) begin
      if (!in_pay_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == 3'd7) in_pay_q <= 1'b1;
      end else if (dat_last_i) begin
        in_pay_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/udp_hdr_insert.sv
`timescale 1ns/1ps
module udp_hdr_insert
  import udp_ins_pkg::*;
#(
  parameter int unsigned DATA_DEPTH = 64,
  parameter int unsigned HDR_DEPTH  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] src_port_i,
  input  logic [15:0] dst_port_i,
  input  logic [31:0] src_ip_i,
  input  logic [31:0] dst_ip_i,
  input  logic [7:0]  s_tdata_i,
  input  logic        s_tvalid_i,
  input  logic        s_tlast_i,
  output logic        s_tready_o,
  output logic [7:0]  m_tdata_o,
  output logic        m_tvalid_o,
  output logic        m_tlast_o,
  input  logic        m_tready_i
);
  localparam int unsigned HW = $bits(udp_hdr_t);

  logic     data_full, data_empty, hdr_full, hdr_empty;
  logic     beat, hdr_pop, dat_pop;
  logic [8:0] dat_rd;
  udp_hdr_t hdr_new, hdr_rd;

  assign s_tready_o = !data_full && !hdr_full;
  assign beat       = s_tvalid_i && s_tready_o;

  udp_ins_sum i_sum (
    .clk_i, .rst_ni,
    .beat_i(beat), .byte_i(s_tdata_i), .last_i(s_tlast_i),
    .src_port_i, .dst_port_i, .src_ip_i, .dst_ip_i,
    .hdr_o(hdr_new)
  );

  udp_ins_fifo #(.WIDTH(9), .DEPTH(DATA_DEPTH)) i_data_fifo (
    .clk_i, .rst_ni,
    .push_i(beat), .wdata_i({s_tlast_i, s_tdata_i}),
    .pop_i(dat_pop), .rdata_o(dat_rd),
    .empty_o(data_empty), .full_o(data_full)
  );

  udp_ins_fifo #(.WIDTH(HW), .DEPTH(HDR_DEPTH)) i_hdr_fifo (
    .clk_i, .rst_ni,
    .push_i(beat && s_tlast_i), .wdata_i(hdr_new),
    .pop_i(hdr_pop), .rdata_o(hdr_rd),
    .empty_o(hdr_empty), .full_o(hdr_full)
  );

  udp_ins_tx i_tx (
    .clk_i, .rst_ni,
    .hdr_i(hdr_rd), .hdr_empty_i(hdr_empty), .hdr_pop_o(hdr_pop),
    .dat_i(dat_rd[7:0]), .dat_last_i(dat_rd[8]), .dat_empty_i(data_empty),
    .dat_pop_o(dat_pop),
    .m_tdata_o, .m_tvalid_o, .m_tlast_o, .m_tready_i
  );
endmodule

// File: rtl/udp_hdr_insert_chk.sv
`timescale 1ns/1ps
module udp_hdr_insert_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       s_tready_i,
  input logic [7:0] m_tdata_i,
  input logic       m_tvalid_i,
  input logic       m_tlast_i,
  input logic       m_tready_i,
  input logic       data_full_i,
  input logic       hdr_full_i
);
  logic [15:0] pos_q;
  logic [7:0]  cks_hi_q;
  logic        hs;
  assign hs = m_tvalid_i && m_tready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      cks_hi_q <= '0;
    end else if (hs) begin
      pos_q <= m_tlast_i ? '0 : ((pos_q == 16'hFFFF) ? pos_q : pos_q + 1'b1);
      if (pos_q == 16'd6) cks_hi_q <= m_tdata_i;
    end
  end

  assert_hdr_no_last_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_i && pos_q < 16'd8) |-> !m_tlast_i);

  assert_cks_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && pos_q == 16'd7) |-> (cks_hi_q != 8'h00 || m_tdata_i != 8'h00));

  assert_last_after_hdr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_i && m_tlast_i) |-> pos_q >= 16'd8);

  assert_out_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_i && !m_tready_i) |=> (m_tvalid_i && $stable(m_tdata_i) && $stable(m_tlast_i)));

  assert_full_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_full_i || hdr_full_i) |-> !s_tready_i);
endmodule

bind udp_hdr_insert udp_hdr_insert_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_tready_i(s_tready_o),
  .m_tdata_i(m_tdata_o), .m_tvalid_i(m_tvalid_o), .m_tlast_i(m_tlast_o),
  .m_tready_i(m_tready_i), .data_full_i(data_full), .hdr_full_i(hdr_full)
);

// File: tb/test_udp_hdr_insert.sv
`timescale 1ns/1ps
module test_udp_hdr_insert;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] sport, dport;
  logic [31:0] sip, dip;
  logic [7:0]  s_tdata;
  logic        s_tvalid, s_tlast, s_tready;
  logic [7:0]  m_tdata;
  logic        m_tvalid, m_tlast, m_tready;

  always #5 clk = ~clk;

  udp_hdr_insert i_udp_hdr_insert (
    .clk_i(clk), .rst_ni(rst_n),
    .src_port_i(sport), .dst_port_i(dport), .src_ip_i(sip), .dst_ip_i(dip),
    .s_tdata_i(s_tdata), .s_tvalid_i(s_tvalid), .s_tlast_i(s_tlast), .s_tready_o(s_tready),
    .m_tdata_o(m_tdata), .m_tvalid_o(m_tvalid), .m_tlast_o(m_tlast), .m_tready_i(m_tready)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] pbuf [0:63];
  logic [7:0] exp_d [$];
  bit         exp_l [$];
  string      exp_t [$];
  bit out_stall = 0, rand_rdy = 0, rand_vld = 0;
  logic [15:0] lfsr_d = 16'hACE1, lfsr_m = 16'h1D2B;

  function automatic logic [15:0] step(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fold_sum(int n);
    logic [31:0] s;
    logic [15:0] len;
    len = 16'(n + 8);
    s = {16'h0, sip[31:16]} + {16'h0, sip[15:0]} + {16'h0, dip[31:16]} + {16'h0, dip[15:0]}
      + 32'd17 + {16'h0, len} + {16'h0, len} + {16'h0, sport} + {16'h0, dport};
    for (int i = 0; i < n; i++)
      s += (i % 2 == 0) ? {16'h0, pbuf[i], 8'h0} : {24'h0, pbuf[i]};
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    return s[15:0];
  endfunction

  task automatic push_exp(logic [7:0] d, bit l, string t);
    exp_d.push_back(d); exp_l.push_back(l); exp_t.push_back(t);
  endtask

  task automatic send_frame(int n, bit zero_case);
    logic [15:0] c, len;
    int i;
    len = 16'(n + 8);
    c = ~fold_sum(n);
    if (c == 16'h0) c = 16'hFFFF;
    push_exp(sport[15:8], 0, "R1 sport"); push_exp(sport[7:0], 0, "R1 sport");
    push_exp(dport[15:8], 0, "R1 dport"); push_exp(dport[7:0], 0, "R1 dport");
    push_exp(len[15:8], 0, "R2 len");     push_exp(len[7:0], 0, "R2 len");
    push_exp(c[15:8], 0, zero_case ? "R4 cks" : "R3 cks");
    push_exp(c[7:0], 0, zero_case ? "R4 cks" : "R3 cks");
    for (int k = 0; k < n; k++) push_exp(pbuf[k], k == n-1, "R5 payload");
    i = 0;
    while (i < n) begin
      @(negedge clk);
      lfsr_d = step(lfsr_d);
      if (rand_vld && lfsr_d[0]) s_tvalid = 1'b0;
      else begin
        s_tvalid = 1'b1; s_tdata = pbuf[i]; s_tlast = (i == n-1);
        #4;
        if (s_tready) i++;
      end
    end
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic set_cfg(int k);
    sport = 16'h1000 + 16'(k);
    dport = 16'hC000 ^ 16'(k * 3);
    sip   = 32'hC0A80000 + 32'(k);
    dip   = 32'h0A000001 * 32'(k + 1);
  endtask

  task automatic drain();
    while (exp_d.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #4 chk(!m_tvalid, "R5 idle after drain", m_tvalid, 0);
  endtask

  // output monitor
  bit prev_v = 0;
  logic [7:0] prev_d;
  bit prev_l;
  initial begin
    m_tready = 1'b0;
    forever begin
      @(negedge clk);
      lfsr_m = step(lfsr_m);
      m_tready = !out_stall && (!rand_rdy || lfsr_m[0]);
      #4;
      if (rst_n) begin
        if (prev_v)
          chk(m_tvalid && m_tdata == prev_d && m_tlast == prev_l, "R6 hold",
              {m_tvalid, m_tdata}, {1'b1, prev_d});
        if (m_tvalid && m_tready) begin
          if (exp_d.size() == 0) chk(0, "R5 extra byte", m_tdata, 0);
          else begin
            logic [7:0] d; bit l; string t;
            d = exp_d.pop_front(); l = exp_l.pop_front(); t = exp_t.pop_front();
            chk(m_tdata == d && m_tlast == l, t, {m_tlast, m_tdata}, {l, d});
          end
        end
        prev_v = m_tvalid && !m_tready;
        prev_d = m_tdata; prev_l = m_tlast;
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    rst_n = 1'b0; s_tvalid = 1'b0; s_tlast = 1'b0; s_tdata = '0;
    set_cfg(0);
    repeat (3) @(negedge clk);
    #4 chk(!m_tvalid && s_tready, "R8 during reset", {m_tvalid, s_tready}, 2'b01);
    @(negedge clk); rst_n = 1'b1;
    #4 chk(!m_tvalid && s_tready, "R8 after reset", {m_tvalid, s_tready}, 2'b01);

    // sweep lengths, free-flowing
    for (int n = 1; n <= 24; n++) begin
      set_cfg(n);
      for (int i = 0; i < n; i++) pbuf[i] = 8'((i * 37 + n) & 8'hFF);
      send_frame(n, 0);
    end
    drain();

    // sweep with random gaps and backpressure
    rand_rdy = 1; rand_vld = 1;
    for (int n = 1; n <= 24; n++) begin
      set_cfg(n + 100);
      for (int i = 0; i < n; i++) pbuf[i] = (n % 2 == 0) ? 8'hFF : 8'(i);
      send_frame(n, 0);
    end
    set_cfg(7);
    for (int i = 0; i < 64; i++) pbuf[i] = 8'(255 - i);
    send_frame(64, 0);
    drain();

    // checksum that folds to zero -> sent as 0xFFFF (R4)
    for (int n = 2; n <= 12; n += 2) begin
      set_cfg(n + 50);
      for (int i = 0; i < n; i++) pbuf[i] = 8'(i * 11);
      pbuf[n-2] = 8'h00; pbuf[n-1] = 8'h00;
      w = 16'hFFFF - fold_sum(n);
      pbuf[n-2] = w[15:8]; pbuf[n-1] = w[7:0];
      send_frame(n, 1);
    end
    drain();

    // header FIFO full stalls input (R7)
    rand_rdy = 0; rand_vld = 0; out_stall = 1;
    set_cfg(3); pbuf[0] = 8'hA5; send_frame(1, 0);
    set_cfg(4); pbuf[0] = 8'h5A; send_frame(1, 0);
    @(negedge clk); #4 chk(!s_tready, "R7 header fifo full", s_tready, 0);
    out_stall = 0;
    drain();

    // data FIFO full stalls input (R7)
    out_stall = 1;
    set_cfg(9);
    for (int i = 0; i < 64; i++) pbuf[i] = 8'(i ^ 8'h3C);
    send_frame(64, 0);
    @(negedge clk); #4 chk(!s_tready, "R7 data fifo full", s_tready, 0);
    out_stall = 0;
    drain();

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule